// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block holds a small power-control register and turns its bits into clock enables and hold controls for the rest of the chip. The CPU writes the register. Setting the idle bit stops the CPU clock while the interrupt, timer, serial and counter-array logic keep running. The counter array may instead be paused, depending on a configuration input. Any enabled interrupt clears the idle bit in hardware, and the CPU clock comes back. Setting the power-down bit asks for the oscillator to stop and removes every clock enable. Only a reset leaves power-down.

Two general-purpose flag bits sit in the same register. Software can use them to tell an interrupt taken during idle from one taken in normal running. A warm reset clears the mode bits and keeps the flags. A power-on reset clears both.

All enables are registered on the falling clock edge. A downstream AND gate with the clock therefore never sees the enable change while the clock is high, so it cannot produce a runt pulse.

Top module: `pmode_ctrl`

## Requirements
- R1: After either reset, reg_rdata mode bits are 0, cpu_clk_en, per_clk_en and cnt_clk_en are 1, and osc_stop, port_hold and strobe_hold are 0.
- R2: A write with bit 0 set enters idle. reg_rdata bit 0 reads 1 after the write edge. cpu_clk_en stays 1 until the following falling edge and is 0 after it, so the write edge is the last enabled CPU edge.
- R3: In idle, per_clk_en stays 1 and cnt_clk_en equals cnt_run_idle (1 keeps the counter array running, 0 pauses it). Outside idle and power-down, cnt_clk_en is 1.
- R4: port_hold and strobe_hold are 1 whenever idle or power-down is set, and 0 otherwise.
- R5: irq_pending high on a rising edge while idle is set and power-down is clear clears the idle bit, and cpu_clk_en returns to 1 at the next falling edge. irq_pending has no effect when neither mode bit is set.
- R6: A write with bit 1 set enters power-down: osc_stop is 1 and all three clock enables are 0. With bits 0 and 1 both set, the outputs equal those of power-down alone.
- R7: In power-down, register writes and irq_pending are ignored and reg_rdata does not change. Only a reset leaves power-down.
- R8: While idle is set, register writes are ignored.
- R9: Bits 3:2 are read/write flag storage that reads back as written. Bits 7:4 ignore writes and read 0.
- R10: A low sys_rst_n clears bits 1:0 and keeps bits 3:2. A low por_rst_n clears bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | Warm reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| irq_pending | input | 1 | An enabled interrupt is pending |
| cnt_run_idle | input | 1 | 1: counter array runs during idle; 0: it pauses |
| cpu_clk_en | output | 1 | CPU clock enable, changes on falling edge |
| per_clk_en | output | 1 | Interrupt/timer/serial clock enable |
| cnt_clk_en | output | 1 | Counter-array clock enable |
| osc_stop | output | 1 | Request to freeze the oscillator |
| port_hold | output | 1 | Hold port pins at their entry values |
| strobe_hold | output | 1 | Hold bus strobes high |

## Verification
The bench sweeps every value of the low four register bits, each with the counter-array option both on and off, and compares the mode outputs with a model computed from the two mode bits. This separates idle alone, power-down alone and both together, and shows whether the counter enable follows the option only in idle. Each pattern is then given a write and an interrupt pulse, which shows which of the two the current mode honours. Flag writes with the upper bits set, followed by warm and power-on resets, show which bits each reset clears.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    typedef struct packed {
        logic idle;
        logic pd;
    } mode_t;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic cnt_en;
        logic osc_stop;
        logic port_hold;
        logic strobe_hold;
    } gate_t;

endpackage

// File: rtl/pmode_reg.sv
module pmode_reg
    import pmode_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int IDLE_BIT = 0,
    parameter int PD_BIT   = 1,
    parameter int GF_LSB   = 2,
    parameter int GF_N     = 2
) (
    input  logic             clk,
    input  logic             rst_any_n,
    input  logic             por_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             irq_pending,
    output mode_t            mode_o,
    output logic [REG_W-1:0] rdata
);

    localparam int GF_MSB = GF_LSB + GF_N - 1;

    mode_t           mode_d, mode_q;
    logic [GF_N-1:0] gf_d, gf_q;

    // Next-state: power-down freezes everything, idle only listens for wake-up
    always_comb begin
        mode_d = mode_q;
        gf_d   = gf_q;
        if (mode_q.pd) begin
            mode_d = mode_q;
        end else if (mode_q.idle) begin
            if (irq_pending) begin
                mode_d.idle = 1'b0;
            end
        end else if (wr_en) begin
            mode_d.idle = wdata[IDLE_BIT];
            mode_d.pd   = wdata[PD_BIT];
            gf_d        = wdata[GF_MSB:GF_LSB];
        end
    end

    // Mode bits: cleared by any reset
    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Flag bits: cleared by power-on reset only
    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) begin
            gf_q <= '0;
        end else begin
            gf_q <= gf_d;
        end
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_rd
        if (i == IDLE_BIT) begin : g_idle
            assign rdata[i] = mode_q.idle;
        end else if (i == PD_BIT) begin : g_pd
            assign rdata[i] = mode_q.pd;
        end else if (i >= GF_LSB && i <= GF_MSB) begin : g_gf
            assign rdata[i] = gf_q[i-GF_LSB];
        end else begin : g_zero
            assign rdata[i] = 1'b0;
        end
    end

    assign mode_o = mode_q;

    p_wake_r5: assert property (@(posedge clk) disable iff (!rst_any_n)
        (mode_q.idle && !mode_q.pd && irq_pending) |=> !mode_q.idle);

    p_pd_sticky_r7: assert property (@(posedge clk) disable iff (!rst_any_n)
        mode_q.pd |=> (mode_q.pd && $stable(gf_q)));

    p_idle_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_any_n)
        (mode_q.idle && !mode_q.pd && !irq_pending) |=> (mode_q.idle && $stable(gf_q)));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_any_n)
        !wr_en |=> $stable(gf_q));

endmodule

// File: rtl/pmode_gate.sv
module pmode_gate
    import pmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_any_n,
    input  mode_t mode_i,
    input  logic  cnt_run_idle,
    output gate_t gate_o
);

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d.osc_stop    = mode_i.pd;
        gate_d.per_en      = !mode_i.pd;
        gate_d.cpu_en      = !(mode_i.pd || mode_i.idle);
        gate_d.port_hold   = mode_i.pd || mode_i.idle;
        gate_d.strobe_hold = mode_i.pd || mode_i.idle;
        if (mode_i.pd) begin
            gate_d.cnt_en = 1'b0;
        end else if (mode_i.idle) begin
            gate_d.cnt_en = cnt_run_idle;
        end else begin
            gate_d.cnt_en = 1'b1;
        end
    end

    // Falling-edge register: enables only move while the clock is low
    always_ff @(negedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            gate_q <= '{cpu_en: 1'b1, per_en: 1'b1, cnt_en: 1'b1,
                        osc_stop: 1'b0, port_hold: 1'b0, strobe_hold: 1'b0};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gate_o = gate_q;

    p_cpu_off_r2: assert property (@(posedge clk) disable iff (!rst_any_n)
        (mode_i.idle || mode_i.pd) |-> !gate_q.cpu_en);

    p_per_idle_r3: assert property (@(posedge clk) disable iff (!rst_any_n)
        (mode_i.idle && !mode_i.pd) |-> gate_q.per_en);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_any_n)
        (mode_i.idle || mode_i.pd) |-> (gate_q.port_hold && gate_q.strobe_hold));

    p_pd_stop_r6: assert property (@(posedge clk) disable iff (!rst_any_n)
        mode_i.pd |-> (gate_q.osc_stop && !gate_q.per_en && !gate_q.cnt_en));

endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
    import pmode_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int IDLE_BIT = 0,
    parameter int PD_BIT   = 1,
    parameter int GF_LSB   = 2,
    parameter int GF_N     = 2
) (
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic             sys_rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             irq_pending,
    input  logic             cnt_run_idle,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             cnt_clk_en,
    output logic             osc_stop,
    output logic             port_hold,
    output logic             strobe_hold
);

    logic  rst_any_n;
    mode_t mode;
    gate_t gate;

    assign rst_any_n = por_rst_n & sys_rst_n;

    pmode_reg #(
        .REG_W    (REG_W),
        .IDLE_BIT (IDLE_BIT),
        .PD_BIT   (PD_BIT),
        .GF_LSB   (GF_LSB),
        .GF_N     (GF_N)
    ) u_reg (
        .clk         (clk),
        .rst_any_n   (rst_any_n),
        .por_rst_n   (por_rst_n),
        .wr_en       (reg_wr),
        .wdata       (reg_wdata),
        .irq_pending (irq_pending),
        .mode_o      (mode),
        .rdata       (reg_rdata)
    );

    pmode_gate u_gate (
        .clk          (clk),
        .rst_any_n    (rst_any_n),
        .mode_i       (mode),
        .cnt_run_idle (cnt_run_idle),
        .gate_o       (gate)
    );

    assign cpu_clk_en  = gate.cpu_en;
    assign per_clk_en  = gate.per_en;
    assign cnt_clk_en  = gate.cnt_en;
    assign osc_stop    = gate.osc_stop;
    assign port_hold   = gate.port_hold;
    assign strobe_hold = gate.strobe_hold;

endmodule

// File: tb/pmode_ctrl_test.sv
module pmode_ctrl_test;

    logic       clk = 1'b0;
    logic       por_rst_n = 1'b0;
    logic       sys_rst_n = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_pending = 1'b0;
    logic       cnt_run_idle = 1'b0;
    logic       cpu_clk_en, per_clk_en, cnt_clk_en, osc_stop, port_hold, strobe_hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pmode_ctrl uut (
        .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pending(irq_pending), .cnt_run_idle(cnt_run_idle),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .cnt_clk_en(cnt_clk_en),
        .osc_stop(osc_stop), .port_hold(port_hold), .strobe_hold(strobe_hold)
    );

    function automatic logic [5:0] outs();
        return {cpu_clk_en, per_clk_en, cnt_clk_en, osc_stop, port_hold, strobe_hold};
    endfunction

    // {cpu, per, cnt, osc_stop, port_hold, strobe_hold}
    function automatic logic [5:0] model(input logic idle, input logic pd, input logic cfg);
        logic cnt;
        cnt = pd ? 1'b0 : (idle ? cfg : 1'b1);
        return {~(idle | pd), ~pd, cnt, pd, idle | pd, idle | pd};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(posedge clk); #1; reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk); #1; reg_wr = 1'b0;
    endtask

    task automatic do_irq();
        @(posedge clk); #1; irq_pending = 1'b1;
        @(posedge clk); #1; irq_pending = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic warm_reset();
        @(posedge clk); #1; sys_rst_n = 1'b0;
        #8; sys_rst_n = 1'b1;
    endtask

    task automatic cold_reset();
        @(posedge clk); #1; por_rst_n = 1'b0;
        #8; por_rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        #13; por_rst_n = 1'b1;
        settle();
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 outs", {2'b0, outs()}, {2'b0, model(1'b0, 1'b0, 1'b0)});

        do_write(8'h0C);
        chk("R9 flags", reg_rdata, 8'h0C);
        do_write(8'hF4);
        chk("R9 upper ignored", reg_rdata, 8'h04);
        warm_reset(); settle();
        chk("R10 warm keeps flags", reg_rdata, 8'h04);
        chk("R1 outs after warm", {2'b0, outs()}, {2'b0, model(1'b0, 1'b0, 1'b0)});
        cold_reset(); settle();
        chk("R10 cold clears flags", reg_rdata, 8'h00);

        for (int cfg = 0; cfg < 2; cfg++) begin
            for (int v = 0; v < 16; v++) begin
                logic idle, pd;
                idle = v[0]; pd = v[1];
                warm_reset(); settle();
                cnt_run_idle = cfg[0];
                do_write(8'hA0 | v[7:0]);
                chk("R9 R2 R6 readback", reg_rdata, v[7:0]);
                chk("R2 enable held to falling edge", {7'b0, cpu_clk_en}, 8'h01);
                settle();
                chk("R2 R3 R4 R6 outs", {2'b0, outs()}, {2'b0, model(idle, pd, cfg[0])});
                held = reg_rdata;
                if (pd) begin
                    do_write(8'h00); settle();
                    chk("R7 write ignored in pd", reg_rdata, held);
                    do_irq(); settle();
                    chk("R7 irq ignored in pd", reg_rdata, held);
                    chk("R7 outs stay pd", {2'b0, outs()}, {2'b0, model(idle, 1'b1, cfg[0])});
                end else if (idle) begin
                    do_write(8'h00); settle();
                    chk("R8 write ignored in idle", reg_rdata, held);
                    do_irq();
                    chk("R5 idle bit cleared", reg_rdata, held & 8'hFE);
                    settle();
                    chk("R5 cpu clock back", {2'b0, outs()}, {2'b0, model(1'b0, 1'b0, cfg[0])});
                end else begin
                    do_irq(); settle();
                    chk("R5 irq no effect when running", reg_rdata, held);
                    chk("R5 outs running", {2'b0, outs()}, {2'b0, model(1'b0, 1'b0, cfg[0])});
                end
            end
        end

        warm_reset(); settle();
        chk("R7 reset leaves pd", reg_rdata & 8'h03, 8'h00);
        chk("R1 outs final", {2'b0, outs()}, {2'b0, model(1'b0, 1'b0, 1'b0)});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule